// File: doc/BRIEF.md
# Cell Polling Tick Scheduler

This block sets the control-period timing for a master controller and three cell sub-controllers that share one message channel. A timer divides the system clock into control ticks. At a fixed offset inside each tick the master puts out a broadcast frame. The frame holds a rotating cell number, an even-parity bit and the two reference words supplied by the master's control arithmetic. Every third tick also raises a synchronization pulse for the cells.

Each cell node watches the broadcast for its own number and arms a reply. In the following tick, at a report slot placed one cycle before that tick's broadcast, the armed cell puts its measured link voltage on the channel. The channel has a fixed-priority arbiter, so at most one report can be driven per slot. The master keeps a table holding the last voltage received from each cell. When the cell it polled does not answer, the old table value stays and a per-cell missed-report counter goes up by one. `chan_corrupt` models a fault in transit that damages the broadcast parity. `cell_mute` models a cell that is offline.

Top module: `ctrl_tick_sched`

## Requirements
- R1: `tick` is high for exactly one cycle out of every TICK_DIV cycles. The first tick is the first cycle after the internal two-stage reset synchronizer releases. `tick` is low while reset is held.
- R2: `sync_pulse` is high only together with `tick`, on tick numbers 0, 3, 6, ... counted from the first tick (every SYNC_EVERY ticks).
- R3: `bc_valid` is high exactly once per tick, COMP_CYC+1 cycles after `tick`. In that cycle `bc_pwm` and `bc_phase` equal the `ref_pwm` and `ref_phase` inputs.
- R4: The broadcast cell number on `bc_addr` is 1 in tick 0 and then steps 1, 2, 3, 1, ... once per tick. `bc_par` is the XOR of the `bc_addr` bits, inverted when `chan_corrupt` is high in the broadcast cycle.
- R5: The report slot is COMP_CYC cycles after `tick`, one cycle before the broadcast. `rpt_valid` can only be high in that slot.
- R6: In tick k+1 the cell addressed in tick k reports, provided the frame was accepted and the cell is not muted. It reports with `rpt_cell` equal to its number (1..3) and `rpt_volt` equal to its `cell_volt` slice. At most one report is sent per tick, and tick 0 has none.
- R7: A cell ignores a broadcast whose parity check fails or whose number is outside 1..3. No report follows in the next tick.
- R8: A cell whose `cell_mute` bit is high in the report slot sends nothing.
- R9: When the polled cell has not reported by the end of the tick, that cell's entry in `volt_table` is unchanged and its `miss_cnt` field rises by one (saturating). The change is visible from the next `tick` cycle, and a counter changes at no other time.
- R10: A received report writes `rpt_volt` into the `volt_table` entry of `rpt_cell` (cell c at bits c*VW-1 down to (c-1)*VW). The write is visible from the cycle after the report slot.
- R11: While reset is held, `volt_table` and `miss_cnt` are all zero and `bc_valid` and `rpt_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pwm | input | RW | Modulator reference from master arithmetic |
| ref_phase | input | RW | Output phase command from master arithmetic |
| cell_volt | input | N_CELLS*VW | Measured link voltage of each cell, cell 1 in low bits |
| cell_mute | input | N_CELLS | Cell offline, bit 0 = cell 1 |
| chan_corrupt | input | 1 | Damage the broadcast parity in transit |
| tick | output | 1 | Control tick strobe |
| sync_pulse | output | 1 | Cell synchronization strobe |
| bc_valid | output | 1 | Broadcast frame on channel |
| bc_addr | output | AW | Polled cell number |
| bc_par | output | 1 | Delivered parity of cell number |
| bc_pwm | output | RW | Broadcast modulator reference |
| bc_phase | output | RW | Broadcast phase command |
| rpt_valid | output | 1 | Report frame on channel |
| rpt_cell | output | AW | Reporting cell number |
| rpt_volt | output | VW | Reported voltage |
| volt_table | output | N_CELLS*VW | Last received voltage per cell |
| miss_cnt | output | N_CELLS*MW | Missed-report count per cell |

## Verification
The assertions check several properties on every cycle. A sync strobe only comes with a tick. Ticks are isolated. Channel frames carry cell numbers in range. A report is always followed directly by a broadcast, and the two never share a cycle. The voltage table changes only right after a report, and miss counters change only at a tick boundary. Other behaviour can only be shown by the bench's scenarios, which track the sequence across ticks. These are the exact slot offsets, the rotating address order, which cell answers one tick later and with what voltage, and the effects of a corrupted frame or a muted cell on the table and counters.

// File: rtl/tick_sched_pkg.sv
package tick_sched_pkg;
  // even parity over a small field, zero-extended by the caller
  function automatic logic even_par(input logic [7:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/tick_sched_timer.sv
module tick_sched_timer #(
  parameter int TICK_DIV   = 40,
  parameter int COMP_CYC   = 12,
  parameter int N_CELLS    = 3,
  parameter int SYNC_EVERY = 3,
  parameter int AW         = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          tick_o,
  output logic          sync_o,
  output logic          rpt_slot_o,
  output logic          bc_slot_o,
  output logic          end_tick_o,
  output logic [AW-1:0] addr_o
);
  localparam int CW  = $clog2(TICK_DIV);
  localparam int SW  = $clog2(SYNC_EVERY + 1);
  localparam logic [CW-1:0] LAST   = CW'(TICK_DIV - 1);
  localparam logic [CW-1:0] RPT_AT = CW'(COMP_CYC);
  localparam logic [CW-1:0] BC_AT  = CW'(COMP_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] acnt_q, acnt_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic          last;

  assign last = (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    acnt_d = acnt_q;
    scnt_d = scnt_q;
    if (last) begin
      cnt_d  = '0;
      acnt_d = (acnt_q == AW'(N_CELLS - 1)) ? '0 : acnt_q + AW'(1);
      scnt_d = (scnt_q == SW'(SYNC_EVERY - 1)) ? '0 : scnt_q + SW'(1);
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acnt_q <= '0;
      scnt_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      acnt_q <= acnt_d;
      scnt_q <= scnt_d;
    end
  end

  assign tick_o     = rst_n && (cnt_q == '0);
  assign sync_o     = tick_o && (scnt_q == '0);
  assign rpt_slot_o = (cnt_q == RPT_AT);
  assign bc_slot_o  = (cnt_q == BC_AT);
  assign end_tick_o = last;
  assign addr_o     = acnt_q + AW'(1);
endmodule

// File: rtl/tick_sched_cell.sv
module tick_sched_cell
  import tick_sched_pkg::*;
#(
  parameter int CELL_ID = 1,
  parameter int N_CELLS = 3,
  parameter int AW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bc_valid,
  input  logic [AW-1:0] bc_addr,
  input  logic          bc_par,
  input  logic          rpt_slot,
  input  logic          mute,
  output logic          req
);
  logic pend_q, pend_d;
  logic frame_ok;

  // accepted only with good parity and an in-range number
  assign frame_ok = (bc_par == even_par(8'(bc_addr))) &&
                    (bc_addr != '0) && (bc_addr <= AW'(N_CELLS));

  always_comb begin
    pend_d = pend_q;
    if (rpt_slot) pend_d = 1'b0;
    if (bc_valid && frame_ok && (bc_addr == AW'(CELL_ID))) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign req = pend_q && rpt_slot && !mute;
endmodule

// File: rtl/tick_sched_master.sv
module tick_sched_master #(
  parameter int N_CELLS = 3,
  parameter int AW      = 2,
  parameter int VW      = 12,
  parameter int MW      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bc_valid,
  input  logic [AW-1:0]              bc_addr,
  input  logic                       rpt_slot,
  input  logic                       end_tick,
  input  logic                       rpt_valid,
  input  logic [AW-1:0]              rpt_cell,
  input  logic [VW-1:0]              rpt_volt,
  output logic [N_CELLS-1:0][VW-1:0] volt_o,
  output logic [N_CELLS-1:0][MW-1:0] miss_o
);
  logic [N_CELLS-1:0][VW-1:0] volt_q, volt_d;
  logic [N_CELLS-1:0][MW-1:0] miss_q, miss_d;
  logic          exp_v_q, exp_v_d;
  logic [AW-1:0] exp_c_q, exp_c_d;
  logic          mv_q, mv_d;
  logic [AW-1:0] mc_q, mc_d;

  always_comb begin
    volt_d  = volt_q;
    miss_d  = miss_q;
    exp_v_d = exp_v_q;
    exp_c_d = exp_c_q;
    mv_d    = mv_q;
    mc_d    = mc_q;
    if (rpt_slot) begin
      if (exp_v_q && !(rpt_valid && (rpt_cell == exp_c_q))) begin
        mv_d = 1'b1;
        mc_d = exp_c_q;
      end
      for (int i = 0; i < N_CELLS; i++)
        if (rpt_valid && (rpt_cell == AW'(i + 1))) volt_d[i] = rpt_volt;
    end
    if (end_tick && mv_q) begin
      mv_d = 1'b0;
      for (int i = 0; i < N_CELLS; i++)
        if ((mc_q == AW'(i + 1)) && (miss_q[i] != '1)) miss_d[i] = miss_q[i] + MW'(1);
    end
    if (bc_valid) begin
      exp_v_d = 1'b1;
      exp_c_d = bc_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      volt_q  <= '0;
      miss_q  <= '0;
      exp_v_q <= 1'b0;
      exp_c_q <= '0;
      mv_q    <= 1'b0;
      mc_q    <= '0;
    end else begin
      volt_q  <= volt_d;
      miss_q  <= miss_d;
      exp_v_q <= exp_v_d;
      exp_c_q <= exp_c_d;
      mv_q    <= mv_d;
      mc_q    <= mc_d;
    end
  end

  assign volt_o = volt_q;
  assign miss_o = miss_q;
endmodule

// File: rtl/ctrl_tick_sched.sv
module ctrl_tick_sched #(
  parameter int TICK_DIV   = 40,
  parameter int COMP_CYC   = 12,
  parameter int N_CELLS    = 3,
  parameter int SYNC_EVERY = 3,
  parameter int VW         = 12,
  parameter int RW         = 16,
  parameter int MW         = 8,
  parameter int AW         = $clog2(N_CELLS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [RW-1:0]         ref_pwm,
  input  logic [RW-1:0]         ref_phase,
  input  logic [N_CELLS*VW-1:0] cell_volt,
  input  logic [N_CELLS-1:0]    cell_mute,
  input  logic                  chan_corrupt,
  output logic                  tick,
  output logic                  sync_pulse,
  output logic                  bc_valid,
  output logic [AW-1:0]         bc_addr,
  output logic                  bc_par,
  output logic [RW-1:0]         bc_pwm,
  output logic [RW-1:0]         bc_phase,
  output logic                  rpt_valid,
  output logic [AW-1:0]         rpt_cell,
  output logic [VW-1:0]         rpt_volt,
  output logic [N_CELLS*VW-1:0] volt_table,
  output logic [N_CELLS*MW-1:0] miss_cnt
);
  import tick_sched_pkg::*;

  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic          rpt_slot, bc_slot, end_tick;
  logic [AW-1:0] addr;

  tick_sched_timer #(
    .TICK_DIV(TICK_DIV), .COMP_CYC(COMP_CYC), .N_CELLS(N_CELLS),
    .SYNC_EVERY(SYNC_EVERY), .AW(AW)
  ) u_timer (
    .clk(clk), .rst_n(srst_n), .tick_o(tick), .sync_o(sync_pulse),
    .rpt_slot_o(rpt_slot), .bc_slot_o(bc_slot), .end_tick_o(end_tick),
    .addr_o(addr)
  );

  // broadcast frame; transit fault flips the delivered parity
  assign bc_valid = bc_slot;
  assign bc_addr  = addr;
  assign bc_par   = even_par(8'(addr)) ^ chan_corrupt;
  assign bc_pwm   = ref_pwm;
  assign bc_phase = ref_phase;

  logic [N_CELLS-1:0] req;
  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    tick_sched_cell #(.CELL_ID(g + 1), .N_CELLS(N_CELLS), .AW(AW)) u_cell (
      .clk(clk), .rst_n(srst_n), .bc_valid(bc_valid), .bc_addr(bc_addr),
      .bc_par(bc_par), .rpt_slot(rpt_slot), .mute(cell_mute[g]), .req(req[g])
    );
  end

  // fixed-priority channel arbiter, lowest cell wins
  always_comb begin
    logic found;
    found    = 1'b0;
    rpt_cell = '0;
    rpt_volt = '0;
    for (int i = 0; i < N_CELLS; i++) begin
      if (req[i] && !found) begin
        found    = 1'b1;
        rpt_cell = AW'(i + 1);
        rpt_volt = cell_volt[i*VW +: VW];
      end
    end
    rpt_valid = found;
  end

  tick_sched_master #(.N_CELLS(N_CELLS), .AW(AW), .VW(VW), .MW(MW)) u_master (
    .clk(clk), .rst_n(srst_n), .bc_valid(bc_valid), .bc_addr(bc_addr),
    .rpt_slot(rpt_slot), .end_tick(end_tick), .rpt_valid(rpt_valid),
    .rpt_cell(rpt_cell), .rpt_volt(rpt_volt), .volt_o(volt_table),
    .miss_o(miss_cnt)
  );
endmodule

// File: rtl/ctrl_tick_sched_chk.sv
module ctrl_tick_sched_chk #(
  parameter int N_CELLS = 3,
  parameter int AW      = 2,
  parameter int VW      = 12,
  parameter int MW      = 8
) (
  input logic                  clk,
  input logic                  srst_n,
  input logic                  tick,
  input logic                  sync_pulse,
  input logic                  bc_valid,
  input logic [AW-1:0]         bc_addr,
  input logic                  rpt_valid,
  input logic [AW-1:0]         rpt_cell,
  input logic [N_CELLS*VW-1:0] volt_table,
  input logic [N_CELLS*MW-1:0] miss_cnt
);
  assert_isolated_tick_R1: assert property (@(posedge clk) disable iff (!srst_n)
    tick |=> !tick);
  assert_sync_on_tick_R2: assert property (@(posedge clk) disable iff (!srst_n)
    sync_pulse |-> tick);
  assert_addr_range_R4: assert property (@(posedge clk) disable iff (!srst_n)
    bc_valid |-> (bc_addr != '0) && (bc_addr <= AW'(N_CELLS)));
  assert_report_then_bcast_R5: assert property (@(posedge clk) disable iff (!srst_n)
    rpt_valid |=> bc_valid);
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !(rpt_valid && bc_valid));
  assert_rpt_cell_R6: assert property (@(posedge clk) disable iff (!srst_n)
    rpt_valid |-> (rpt_cell != '0) && (rpt_cell <= AW'(N_CELLS)));
  assert_miss_at_boundary_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (miss_cnt != $past(miss_cnt)) |-> tick);
  assert_table_after_rpt_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (volt_table != $past(volt_table)) |-> $past(rpt_valid));
endmodule

bind ctrl_tick_sched ctrl_tick_sched_chk #(
  .N_CELLS(N_CELLS), .AW(AW), .VW(VW), .MW(MW)
) u_chk (
  .clk(clk), .srst_n(srst_n), .tick(tick), .sync_pulse(sync_pulse),
  .bc_valid(bc_valid), .bc_addr(bc_addr), .rpt_valid(rpt_valid),
  .rpt_cell(rpt_cell), .volt_table(volt_table), .miss_cnt(miss_cnt)
);

// File: tb/ctrl_tick_sched_tb.sv
module ctrl_tick_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV = 40;
  localparam int COMP_CYC = 12;
  localparam int N  = 3;
  localparam int VW = 12;
  localparam int RW = 16;
  localparam int MW = 8;
  localparam int AW = 2;
  localparam int NT = 150;

  logic clk = 1'b0;
  logic rst_n;
  logic [RW-1:0] ref_pwm, ref_phase;
  logic [N*VW-1:0] cell_volt;
  logic [N-1:0] cell_mute;
  logic chan_corrupt;
  logic tick, sync_pulse, bc_valid, bc_par, rpt_valid;
  logic [AW-1:0] bc_addr, rpt_cell;
  logic [RW-1:0] bc_pwm, bc_phase;
  logic [VW-1:0] rpt_volt;
  logic [N*VW-1:0] volt_table;
  logic [N*MW-1:0] miss_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_tick_sched u_dut (
    .clk(clk), .rst_n(rst_n), .ref_pwm(ref_pwm), .ref_phase(ref_phase),
    .cell_volt(cell_volt), .cell_mute(cell_mute), .chan_corrupt(chan_corrupt),
    .tick(tick), .sync_pulse(sync_pulse), .bc_valid(bc_valid), .bc_addr(bc_addr),
    .bc_par(bc_par), .bc_pwm(bc_pwm), .bc_phase(bc_phase), .rpt_valid(rpt_valid),
    .rpt_cell(rpt_cell), .rpt_volt(rpt_volt), .volt_table(volt_table),
    .miss_cnt(miss_cnt)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_addr(input int k);
    return (k % N) + 1;
  endfunction

  function automatic bit exp_par(input int a, input bit bad);
    return bit'(a[0] ^ a[1]) ^ bad;
  endfunction

  logic [VW-1:0] m_volt [N];
  int            m_miss [N];
  logic [VW-1:0] cv [N];
  int  prev_addr;
  bit  prev_ok, prev_v;

  task automatic drive_tick(input int k);
    for (int i = 0; i < N; i++) cv[i] = VW'($urandom);
    for (int i = 0; i < N; i++) cell_volt[i*VW +: VW] = cv[i];
    ref_pwm   = RW'($urandom);
    ref_phase = RW'($urandom);
    if (k < 4) begin
      cell_mute = '0; chan_corrupt = 1'b0;
    end else if (k == 4 || k == 5) begin
      cell_mute = '0; chan_corrupt = 1'b1;
    end else if (k == 9 || k == 10) begin
      cell_mute = '1; chan_corrupt = 1'b0;
    end else begin
      cell_mute    = N'(($urandom % 8 == 0) ? (1 << ($urandom % N)) : 0);
      chan_corrupt = ($urandom % 8 == 0);
    end
  endtask

  task automatic check_tables(input int k);
    for (int i = 0; i < N; i++) begin
      chk(volt_table[i*VW +: VW] == m_volt[i], $sformatf("R10 volt cell%0d tick%0d", i+1, k),
          volt_table[i*VW +: VW], m_volt[i]);
      chk(miss_cnt[i*MW +: MW] == MW'(m_miss[i]), $sformatf("R9 miss cell%0d tick%0d", i+1, k),
          miss_cnt[i*MW +: MW], m_miss[i]);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cell_mute = '0; chan_corrupt = 1'b0;
    ref_pwm = '0; ref_phase = '0; cell_volt = '0;
    for (int i = 0; i < N; i++) begin m_volt[i] = '0; m_miss[i] = 0; end
    prev_v = 0; prev_ok = 0; prev_addr = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(volt_table == '0, "R11 volt_table in reset", volt_table, 0);
    chk(miss_cnt == '0, "R11 miss_cnt in reset", miss_cnt, 0);
    chk(!bc_valid && !rpt_valid, "R11 frames idle in reset", {bc_valid, rpt_valid}, 0);
    chk(!tick, "R1 no tick in reset", tick, 0);
    rst_n = 1'b1;
    begin
      int w = 0;
      while (!tick && w < 10) begin @(negedge clk); #1; w++; end
      chk(tick == 1'b1 && w <= 3, "R1 first tick after reset release", w, 2);
    end
    for (int k = 0; k < NT; k++) begin
      for (int c = 0; c < TICK_DIV; c++) begin
        if (!(k == 0 && c == 0)) @(negedge clk);
        if (c == 0) drive_tick(k);
        #1;
        if (c == 0) begin
          chk(tick == 1'b1, "R1 tick at period start", tick, 1);
          chk(sync_pulse == ((k % 3) == 0), $sformatf("R2 sync tick%0d", k), sync_pulse, (k % 3) == 0);
          check_tables(k);
        end else begin
          chk(tick == 1'b0 && sync_pulse == 1'b0, "R1 no tick mid-period", {tick, sync_pulse}, 0);
        end
        if (c == COMP_CYC) begin
          int er;
          bit rep;
          er  = (prev_v && prev_ok) ? prev_addr : 0;
          rep = (er != 0) && !cell_mute[er-1];
          chk(rpt_valid == rep, $sformatf("R6 R7 R8 report presence tick%0d", k), rpt_valid, rep);
          if (rep) begin
            chk(rpt_cell == AW'(er), "R6 report cell", rpt_cell, er);
            chk(rpt_volt == cv[er-1], "R6 report voltage", rpt_volt, cv[er-1]);
            m_volt[er-1] = cv[er-1];
          end
          if (prev_v && !rep && m_miss[prev_addr-1] < 255) m_miss[prev_addr-1]++;
          chk(!bc_valid, "R5 no broadcast in report slot", bc_valid, 0);
        end else if (c == COMP_CYC + 1) begin
          int a;
          a = exp_addr(k);
          chk(bc_valid == 1'b1, "R3 broadcast slot", bc_valid, 1);
          chk(bc_addr == AW'(a), $sformatf("R4 address tick%0d", k), bc_addr, a);
          chk(bc_par == exp_par(a, chan_corrupt), "R4 parity", bc_par, exp_par(a, chan_corrupt));
          chk(bc_pwm == ref_pwm && bc_phase == ref_phase, "R3 references", {bc_pwm, bc_phase},
              {ref_pwm, ref_phase});
          chk(!rpt_valid, "R5 no report in broadcast slot", rpt_valid, 0);
          prev_addr = a; prev_ok = !chan_corrupt; prev_v = 1;
        end else begin
          chk(!bc_valid && !rpt_valid, "R5 channel idle outside slots", {bc_valid, rpt_valid}, 0);
        end
      end
    end
    @(negedge clk); #1;
    check_tables(NT);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule